// File: doc/BRIEF.md
# Privileged System-Mode Instruction Gate

This block sits in the decode stage of an x86-style core. It recognises a small family of two-byte-opcode instructions that save and restore segment, local-descriptor-table and task registers, together with their hidden descriptor parts, and one instruction that returns the core from system-management mode. For each recognised instruction it checks the ModRM byte and the permission rule. It then produces either a one-hot instruction identity or an invalid-opcode fault.

The decoder pulses `dec_valid` together with the two opcode bytes, the ModRM byte, the current privilege level, a configuration-access enable bit and a flag that is high while a system-management interrupt handler runs. One clock later the block presents a registered result. The result stays unchanged until the next strobe. Opcodes outside the family produce an empty identity and no fault, so the main decoder keeps ownership of them. The permission rule does not depend on where the memory operand lies: a permitted instruction is allowed even when it addresses memory outside the protected system-management region.

Top module: `smg_gate`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid`, `insn_hot`, `seg_sel`, `opnd_m80` and `fault_ud` are all zero.
- R2: `out_valid` is high exactly on the cycle after a clock edge that saw `dec_valid` high. After an edge with `dec_valid` low, `out_valid` is low and the other outputs keep their values.
- R3: With first byte 0x0F, the second byte selects the `insn_hot` bit as follows: 0x78 save segment gives bit 0, 0x79 restore segment gives bit 1, 0x7A save LDTR gives bit 2, 0x7B restore LDTR gives bit 3, 0x7C save task register gives bit 4, 0x7D restore task register gives bit 5, and 0xAA resume gives bit 6. At most one bit is ever high.
- R4: A recognised instruction is permitted only when `cpl` is 0 and at least one of `cfg_acc_en` and `smi_active` is high. Otherwise `fault_ud` is raised.
- R5: For the two segment forms, the ModRM reg field (bits 5:3) must be ES=0, SS=2, DS=3, FS=4 or GS=5, and `seg_sel` returns that value. CS=1 and the reserved values 6 and 7 raise `fault_ud`.
- R6: For the four LDTR and task-register forms, a ModRM reg field other than 0 raises `fault_ud`.
- R7: A ModRM mod field (bits 7:6) of 3 on any of the six memory-operand forms raises `fault_ud`. The resume instruction ignores the ModRM byte.
- R8: `opnd_m80` is 1 for an accepted memory-operand form (an 80-bit operand). It is 0 for resume, for a fault and for an unrecognised opcode.
- R9: An opcode pair outside the seven listed gives `insn_hot` = 0 and `fault_ud` = 0, whatever the ModRM byte and permission inputs are.
- R10: When `fault_ud` is high, `insn_hot`, `seg_sel` and `opnd_m80` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode strobe; the inputs below are sampled when it is high |
| opc_b0 | input | 8 | First opcode byte |
| opc_b1 | input | 8 | Second opcode byte |
| modrm | input | 8 | ModRM byte |
| cpl | input | 2 | Current privilege level |
| cfg_acc_en | input | 1 | Configuration bit that grants system-mode access |
| smi_active | input | 1 | High while a system-management interrupt handler runs |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| insn_hot | output | 7 | One-hot instruction identity |
| seg_sel | output | 3 | Selected segment register for the segment forms |
| opnd_m80 | output | 1 | Memory operand is 80 bits wide |
| fault_ud | output | 1 | Invalid-opcode fault |

## Verification
The bench drives each of the seven opcodes with all 256 ModRM values and all sixteen combinations of privilege level, enable bit and handler flag. A wrong permission rule, such as an OR in place of the AND with privilege level 0, would let level-3 code through. Treating CS or reg values 6 and 7 as legal selections would let a segment form that should fault be accepted. The bench also sweeps neighbouring second bytes such as 0x77 and 0x7E and wrong first bytes. A decoder with a loose range compare would claim those opcodes or fault on them. Finally, the bench checks that the outputs hold while the strobe is low and that resume accepts mod 3. A gate that latched its inputs without the strobe, or that applied the memory-operand rule to resume, would fail those checks.

// File: rtl/smg_pkg.sv
package smg_pkg;

  typedef enum logic {
    SZ_NONE = 1'b0,
    SZ_M80  = 1'b1
  } opsz_e;

  localparam logic [1:0] MOD_REG_DIRECT = 2'b11;
  localparam logic [2:0] SREG_CS        = 3'd1;
  localparam logic [2:0] SREG_LAST      = 3'd5;

  function automatic logic sreg_ok(input logic [2:0] r);
    return (r != SREG_CS) && (r <= SREG_LAST);
  endfunction

endpackage

// File: rtl/smg_opcode_dec.sv
module smg_opcode_dec #(
  parameter int          OPC_W      = 8,
  parameter int          GROUP_LEN  = 6,
  parameter logic [7:0]  ESC_BYTE   = 8'h0F,
  parameter logic [7:0]  GROUP_BASE = 8'h78,
  parameter logic [7:0]  RESUME_OP  = 8'hAA
) (
  input  logic [OPC_W-1:0] b0,
  input  logic [OPC_W-1:0] b1,
  output logic [GROUP_LEN:0] match
);
  logic esc_hit;
  assign esc_hit = (b0 == ESC_BYTE);

  for (genvar g = 0; g < GROUP_LEN; g++) begin : g_slot
    localparam logic [OPC_W-1:0] CODE = OPC_W'(GROUP_BASE + g);
    assign match[g] = esc_hit && (b1 == CODE);
  end

  assign match[GROUP_LEN] = esc_hit && (b1 == RESUME_OP);
endmodule

// File: rtl/smg_form_chk.sv
module smg_form_chk
  import smg_pkg::*;
#(
  parameter int GROUP_LEN = 6,
  parameter int SEG_FORMS = 2
) (
  input  logic [GROUP_LEN:0] match,
  input  logic [7:0]         modrm,
  output logic               form_ok
);
  logic [1:0] mod_f;
  logic [2:0] reg_f;
  logic       mem_ok;
  logic [GROUP_LEN:0] slot_ok;

  assign mod_f  = modrm[7:6];
  assign reg_f  = modrm[5:3];
  assign mem_ok = (mod_f != MOD_REG_DIRECT);

  for (genvar g = 0; g < GROUP_LEN; g++) begin : g_rule
    if (g < SEG_FORMS) begin : g_seg
      assign slot_ok[g] = mem_ok && sreg_ok(reg_f);
    end else begin : g_sys
      assign slot_ok[g] = mem_ok && (reg_f == 3'd0);
    end
  end

  assign slot_ok[GROUP_LEN] = 1'b1;
  assign form_ok = |(match & slot_ok);
endmodule

// File: rtl/smg_perm.sv
module smg_perm #(
  parameter int CPL_W = 2
) (
  input  logic [CPL_W-1:0] cpl,
  input  logic             cfg_acc_en,
  input  logic             smi_active,
  output logic             permit
);
  assign permit = (cpl == '0) && (cfg_acc_en || smi_active);
endmodule

// File: rtl/smg_gate.sv
module smg_gate
  import smg_pkg::*;
#(
  parameter int          OPC_W      = 8,
  parameter int          CPL_W      = 2,
  parameter int          GROUP_LEN  = 6,
  parameter int          SEG_FORMS  = 2,
  parameter logic [7:0]  ESC_BYTE   = 8'h0F,
  parameter logic [7:0]  GROUP_BASE = 8'h78,
  parameter logic [7:0]  RESUME_OP  = 8'hAA
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dec_valid,
  input  logic [OPC_W-1:0]     opc_b0,
  input  logic [OPC_W-1:0]     opc_b1,
  input  logic [7:0]           modrm,
  input  logic [CPL_W-1:0]     cpl,
  input  logic                 cfg_acc_en,
  input  logic                 smi_active,
  output logic                 out_valid,
  output logic [GROUP_LEN:0]   insn_hot,
  output logic [2:0]           seg_sel,
  output logic                 opnd_m80,
  output logic                 fault_ud
);
  localparam int NUM_INSN = GROUP_LEN + 1;

  logic [NUM_INSN-1:0] match;
  logic                form_ok;
  logic                permit;
  logic                hit;
  logic                fault_d;
  logic [NUM_INSN-1:0] insn_d;
  logic [2:0]          seg_d;
  opsz_e               size_d;

  smg_opcode_dec #(
    .OPC_W(OPC_W), .GROUP_LEN(GROUP_LEN), .ESC_BYTE(ESC_BYTE),
    .GROUP_BASE(GROUP_BASE), .RESUME_OP(RESUME_OP)
  ) u_dec (
    .b0(opc_b0), .b1(opc_b1), .match(match)
  );

  smg_form_chk #(.GROUP_LEN(GROUP_LEN), .SEG_FORMS(SEG_FORMS)) u_form (
    .match(match), .modrm(modrm), .form_ok(form_ok)
  );

  smg_perm #(.CPL_W(CPL_W)) u_perm (
    .cpl(cpl), .cfg_acc_en(cfg_acc_en), .smi_active(smi_active), .permit(permit)
  );

  always_comb begin
    hit     = |match;
    fault_d = hit && !(permit && form_ok);
    insn_d  = fault_d ? '0 : match;
    seg_d   = (|insn_d[SEG_FORMS-1:0]) ? modrm[5:3] : 3'd0;
    size_d  = (|insn_d[GROUP_LEN-1:0]) ? SZ_M80 : SZ_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      insn_hot  <= '0;
      seg_sel   <= '0;
      opnd_m80  <= 1'b0;
      fault_ud  <= 1'b0;
    end else begin
      out_valid <= dec_valid;
      if (dec_valid) begin
        insn_hot <= insn_d;
        seg_sel  <= seg_d;
        opnd_m80 <= size_d;
        fault_ud <= fault_d;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> (!out_valid && $stable(insn_hot) && $stable(fault_ud)
                    && $stable(seg_sel) && $stable(opnd_m80)));

  // R3
  onehot_id_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(insn_hot));

  // R4
  perm_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && |insn_hot) |->
      ($past(cpl) == '0 && ($past(cfg_acc_en) || $past(smi_active))));

  // R5
  seg_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (|insn_hot[SEG_FORMS-1:0]) |-> (seg_sel != SREG_CS && seg_sel <= SREG_LAST));

  // R8
  resume_size_chk: assert property (@(posedge clk) disable iff (rst)
    insn_hot[GROUP_LEN] |-> !opnd_m80);

  // R10
  fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fault_ud |-> (insn_hot == '0 && seg_sel == 3'd0 && !opnd_m80));
endmodule

// File: tb/sim_smg_gate.sv
module sim_smg_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_valid = 1'b0;
  logic [7:0] opc_b0 = '0, opc_b1 = '0, modrm = '0;
  logic [1:0] cpl = '0;
  logic       cfg_acc_en = 1'b0, smi_active = 1'b0;
  logic       out_valid, opnd_m80, fault_ud;
  logic [6:0] insn_hot;
  logic [2:0] seg_sel;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [6:0] e_insn;
  logic [2:0] e_seg;
  logic       e_sz, e_f;
  string      e_tag;

  always #4 clk = ~clk;

  smg_gate u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .opc_b0(opc_b0), .opc_b1(opc_b1),
    .modrm(modrm), .cpl(cpl), .cfg_acc_en(cfg_acc_en), .smi_active(smi_active),
    .out_valid(out_valid), .insn_hot(insn_hot), .seg_sel(seg_sel),
    .opnd_m80(opnd_m80), .fault_ud(fault_ud)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic model(input logic [7:0] b0, b1, mr, input logic [1:0] c,
                       input logic ce, sm);
    int  idx;
    bit  rec, perm, fok;
    logic [1:0] md;
    logic [2:0] rg;
    md = mr[7:6];
    rg = mr[5:3];
    rec = 0;
    idx = 0;
    if (b0 == 8'h0F && b1 >= 8'h78 && b1 <= 8'h7D) begin rec = 1; idx = int'(b1) - 'h78; end
    if (b0 == 8'h0F && b1 == 8'hAA) begin rec = 1; idx = 6; end
    perm = (c == 0) && (ce || sm);
    if (idx == 6) fok = 1;
    else if (idx <= 1) fok = (md != 3) && (rg == 0 || (rg >= 2 && rg <= 5));
    else fok = (md != 3) && (rg == 0);
    e_f    = rec && !(perm && fok);
    e_insn = (rec && !e_f) ? 7'(1 << idx) : 7'd0;
    e_seg  = (e_insn[1:0] != 0) ? rg : 3'd0;
    e_sz   = (rec && !e_f && idx != 6);
    if (!rec) e_tag = "R9";
    else if (!perm) e_tag = "R4";
    else if (idx != 6 && md == 3) e_tag = "R7";
    else if (idx <= 1) e_tag = "R5";
    else if (idx != 6) e_tag = "R6";
    else e_tag = "R3";
  endtask

  task automatic compare(input logic exp_v, input string tag);
    checks = checks + 1;
    if ({out_valid, insn_hot, seg_sel, opnd_m80, fault_ud} !==
        {exp_v, e_insn, e_seg, e_sz, e_f}) begin
      failures = failures + 1;
      $display("FAIL %s: actual v=%b id=%b seg=%0d m80=%b ud=%b expected v=%b id=%b seg=%0d m80=%b ud=%b",
               tag, out_valid, insn_hot, seg_sel, opnd_m80, fault_ud,
               exp_v, e_insn, e_seg, e_sz, e_f);
    end
  endtask

  task automatic run(input logic [7:0] b0, b1, mr, input logic [1:0] c,
                     input logic ce, sm, input string tag);
    opc_b0 = b0; opc_b1 = b1; modrm = mr; cpl = c; cfg_acc_en = ce; smi_active = sm;
    dec_valid = 1'b1;
    model(b0, b1, mr, c, ce, sm);
    @(negedge clk);
    compare(1'b1, (tag == "") ? e_tag : tag);
  endtask

  initial begin
    logic [7:0] codes [7];
    codes = '{8'h78, 8'h79, 8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'hAA};
    // R1: reset holds outputs at zero even with a strobe
    dec_valid = 1'b1; opc_b0 = 8'h0F; opc_b1 = 8'h7A; cfg_acc_en = 1'b1;
    repeat (3) @(negedge clk);
    e_insn = '0; e_seg = '0; e_sz = 0; e_f = 0;
    compare(1'b0, "R1");
    rst = 1'b0;
    dec_valid = 1'b0;
    @(negedge clk);
    compare(1'b0, "R1");

    // directed corners
    run(8'h0F, 8'h79, 8'b00_001_000, 2'd0, 1'b1, 1'b0, "R5");   // CS selection
    run(8'h0F, 8'h78, 8'b01_101_010, 2'd0, 1'b0, 1'b1, "R5");   // GS legal
    run(8'h0F, 8'h7B, 8'b00_010_000, 2'd0, 1'b1, 1'b1, "R6");
    run(8'h0F, 8'h7C, 8'b11_000_000, 2'd0, 1'b1, 1'b0, "R7");
    run(8'h0F, 8'hAA, 8'b11_111_111, 2'd0, 1'b1, 1'b0, "R7");
    run(8'h0F, 8'h7D, 8'b00_000_110, 2'd3, 1'b1, 1'b1, "R10");
    run(8'h0F, 8'h7E, 8'b00_000_000, 2'd0, 1'b1, 1'b0, "R9");
    run(8'h0F, 8'h77, 8'b00_000_000, 2'd0, 1'b1, 1'b0, "R9");
    run(8'h0F, 8'h7A, 8'b10_000_100, 2'd0, 1'b1, 1'b0, "R8");

    // R2: strobe low holds result and drops out_valid
    dec_valid = 1'b0; opc_b1 = 8'h78; modrm = 8'h10; cpl = 2'd0;
    @(negedge clk);
    compare(1'b0, "R2");
    @(negedge clk);
    compare(1'b0, "R2");

    // full sweep: R3 R4 R5 R6 R7 R8 R10
    for (int k = 0; k < 7; k++)
      for (int m = 0; m < 256; m++)
        for (int p = 0; p < 16; p++)
          run(8'h0F, codes[k], 8'(m), 2'(p >> 2), p[1], p[0], "");

    // R9: foreign opcodes
    for (int b = 0; b < 256; b++) begin
      run(8'h0E, 8'(b), 8'h00, 2'd0, 1'b1, 1'b1, "R9");
      run(8'hFF, 8'(b), 8'hC0, 2'd3, 1'b0, 1'b0, "R9");
      run(8'h0F, 8'(b), 8'h08, 2'd1, 1'b1, 1'b0, "");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule